// File: doc/BRIEF.md
# Page Translation Cache

This block holds a small set of recently used page mappings and turns a 32-bit virtual byte address into a 30-bit physical byte address. Pages are 4 KiB. The upper 20 bits of the virtual address form the virtual page number. The lower 12 bits pass straight through as the page offset. Each stored mapping pairs a virtual page number with an 18-bit physical page number. Every entry is searched in parallel, so any mapping can sit in any slot.

A lookup is resolved combinationally in the cycle it is presented. The block returns hit or miss, the translated address, and the entry's current reference and dirty bits. On a hit, the reference bit is set. A write hit also sets the dirty bit. After a miss, an external page walker installs a complete entry through the refill port. The refill goes into a slot that already holds the same virtual page, or else into the lowest free slot, or else into the slot picked by a rotating victim pointer. Two more controls act on all entries at once: one clears every reference bit, and one drops every mapping.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and every lookup misses.
- R2: When `lkp_valid` is high and the upper 20 address bits match a valid entry, `lkp_hit` is 1 in the same cycle. `lkp_paddr` is then that entry's 18-bit physical page number concatenated above `lkp_vaddr[11:0]`.
- R3: On a miss, or when `lkp_valid` is low, `lkp_hit`, `lkp_paddr`, `lkp_ref` and `lkp_dirty` are all 0.
- R4: On a hit, `lkp_ref` and `lkp_dirty` show the entry's bits as they were before the current access updates them.
- R5: A hit of either type sets the entry's reference bit at the next clock edge.
- R6: A write hit (`lkp_write`=1) sets the entry's dirty bit. A read hit leaves the dirty bit unchanged.
- R7: `clr_ref` clears every reference bit in one cycle and leaves the dirty bits alone. An entry hit in the same cycle ends with its reference bit set.
- R8: `flush` invalidates every entry at the next edge. It overrides a refill, a hit update and a clear in the same cycle.
- R9: A refill whose virtual page already sits in a valid entry overwrites that entry, so no page is ever held twice.
- R10: Any other refill writes the lowest-numbered invalid entry. When all entries are valid, it writes the entry at the victim pointer. The pointer starts at 0 on reset and advances by one, wrapping, only after such a replacement.
- R11: A refilled entry takes its reference and dirty bits from `fill_ref` and `fill_dirty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | A lookup is presented this cycle |
| lkp_write | input | 1 | The lookup is a store (1) or a load (0) |
| lkp_vaddr | input | 32 | Virtual byte address to translate |
| lkp_hit | output | 1 | The lookup matched a valid entry |
| lkp_paddr | output | 30 | Translated physical byte address, 0 on a miss |
| lkp_ref | output | 1 | Reference bit of the matched entry before update |
| lkp_dirty | output | 1 | Dirty bit of the matched entry before update |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_ppn | input | 18 | Physical page number of the new entry |
| fill_ref | input | 1 | Initial reference bit of the new entry |
| fill_dirty | input | 1 | Initial dirty bit of the new entry |
| clr_ref | input | 1 | Clear every reference bit |
| flush | input | 1 | Invalidate every entry |

## Verification
Several corner cases are targeted directly:
- A clear that coincides with a hit. A design that lets the clear win would report the hit entry as unreferenced afterwards.
- A refill of a page that is already present. A design that duplicates the page would return the OR of the two frame numbers.
- A flush that coincides with a refill. A design that gives the refill priority would leave that page hitting.
- Filling every slot and then refilling past capacity. A design with a wrong victim choice or a wrong pointer advance would evict the wrong page, and a surviving mapping would be missing.
- Address patterns that use all-ones and all-zeros page numbers and offsets. These catch a design that translates the offset bits or misplaces the frame number.

// File: rtl/xlat_pkg.sv
// Package: shared address geometry for the page translation cache.
// Assumes byte addressing with power-of-two page size.
package xlat_pkg;
    localparam int VA_W  = 32;            // virtual address width
    localparam int OFS_W = 12;            // page offset width (4 KiB pages)
    localparam int PPN_W = 18;            // physical page number width
    localparam int VPN_W = VA_W - OFS_W;  // virtual page number width
    localparam int PA_W  = PPN_W + OFS_W; // physical address width
endpackage

// File: rtl/xc_cam.sv
// Module: xc_cam
// Parallel tag compare across all entries. It returns the match vector,
// an any-match flag and the binary index of the match. The index encoder
// ORs indices together, so it assumes at most one entry matches; the top
// level guarantees that by overwriting duplicates on refill.
module xc_cam #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 20,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [KEY_W-1:0]              key,
    input  logic [ENTRIES-1:0]            live,
    input  logic [ENTRIES-1:0][KEY_W-1:0] tags,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IW-1:0]                 idx
);
    // one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = live[g] && (tags[g] == key);
    end

    // encode the (one-hot) match vector into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IW'(i);
        end
        any = |match;
    end
endmodule

// File: rtl/xc_victim.sv
// Module: xc_victim
// Chooses the slot for a refill of a new page. It picks the lowest-numbered
// invalid entry, or the rotating pointer when every entry is valid.
// Assumes the pointer is kept below ENTRIES by the caller.
module xc_victim #(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] live,
    input  logic [IW-1:0]      rr_ptr,
    output logic [IW-1:0]      slot,
    output logic               full
);
    // priority search from the top so the lowest free index wins
    always_comb begin
        full = &live;
        slot = rr_ptr;
        if (!full) begin
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (!live[i]) slot = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_cache.sv
// Module: xlat_cache (top)
// Fully associative page translation cache with per-entry reference and
// dirty bits. The lookup path is combinational. Status updates, refills,
// clears and flushes take effect at the next rising edge.
// Assumes ENTRIES is a power of two between 16 and 512.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_valid,
    input  logic             lkp_write,
    input  logic [VA_W-1:0]  lkp_vaddr,
    output logic             lkp_hit,
    output logic [PA_W-1:0]  lkp_paddr,
    output logic             lkp_ref,
    output logic             lkp_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_ref,
    input  logic             fill_dirty,
    input  logic             clr_ref,
    input  logic             flush
);
    localparam int IW = $clog2(ENTRIES);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [ENTRIES-1:0]            valid_q, ref_q, dirty_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    logic [IW-1:0]                 rr_q;

    logic [ENTRIES-1:0] l_match, f_match;
    logic               l_any, f_any, all_live;
    logic [IW-1:0]      l_idx, f_idx, vic_idx, fill_slot;
    logic               hit_int, replace;

    xc_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_lkp (
        .key(lkp_vaddr[VA_W-1:OFS_W]), .live(valid_q), .tags(vpn_q),
        .match(l_match), .any(l_any), .idx(l_idx)
    );

    xc_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_fill (
        .key(fill_vpn), .live(valid_q), .tags(vpn_q),
        .match(f_match), .any(f_any), .idx(f_idx)
    );

    xc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .live(valid_q), .rr_ptr(rr_q), .slot(vic_idx), .full(all_live)
    );

    // lookup result: frame number above the untranslated offset
    always_comb begin
        hit_int   = lkp_valid && l_any;
        lkp_hit   = hit_int;
        lkp_paddr = hit_int ? {ppn_q[l_idx], lkp_vaddr[OFS_W-1:0]} : '0;
        lkp_ref   = hit_int && ref_q[l_idx];
        lkp_dirty = hit_int && dirty_q[l_idx];
    end

    // refill slot selection: same page first, then free slot or victim
    always_comb begin
        fill_slot = f_any ? f_idx : vic_idx;
        replace   = fill_valid && !f_any && all_live;
    end

    // valid, status bits and victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
            dirty_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (fill_valid && fill_slot == IW'(e)) begin
                    valid_q[e] <= 1'b1;
                    ref_q[e]   <= fill_ref;
                    dirty_q[e] <= fill_dirty;
                end else if (hit_int && l_idx == IW'(e)) begin
                    ref_q[e] <= 1'b1;
                    if (lkp_write) dirty_q[e] <= 1'b1;
                end else if (clr_ref) begin
                    ref_q[e] <= 1'b0;
                end
            end
            if (replace) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // translation payload, written on refill only
    always_ff @(posedge clk) begin
        if (fill_valid && !flush) begin
            vpn_q[fill_slot] <= fill_vpn;
            ppn_q[fill_slot] <= fill_ppn;
        end
    end

    // R9
    lkp_single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l_match));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> lkp_paddr[OFS_W-1:0] == lkp_vaddr[OFS_W-1:0]);

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_hit |-> (lkp_paddr == '0 && !lkp_ref && !lkp_dirty));

    // R5
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_int && !flush && !fill_valid) |=> ref_q[$past(l_idx)]);

    // R6
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_int && lkp_write && !flush && !fill_valid) |=> dirty_q[$past(l_idx)]);

    // R8
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid_q == '0);

    // R7
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref && !flush && !fill_valid && !hit_int) |=> ref_q == '0);

    // R10
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (replace && !flush) |=> rr_q != $past(rr_q));
endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0, lkp_write = 1'b0;
    logic [31:0] lkp_vaddr = '0;
    logic        lkp_hit, lkp_ref, lkp_dirty;
    logic [29:0] lkp_paddr;
    logic        fill_valid = 1'b0, fill_ref = 1'b0, fill_dirty = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [17:0] fill_ppn = '0;
    logic        clr_ref = 1'b0, flush = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_write(lkp_write), .lkp_vaddr(lkp_vaddr),
        .lkp_hit(lkp_hit), .lkp_paddr(lkp_paddr), .lkp_ref(lkp_ref), .lkp_dirty(lkp_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_ref(fill_ref), .fill_dirty(fill_dirty),
        .clr_ref(clr_ref), .flush(flush)
    );

    // vector: write, vaddr, exp hit, exp paddr, exp ref, exp dirty (66 bits)
    localparam logic [65:0] VEC [9] = '{
        {1'b0, 32'h0000_1ABC, 1'b1, 30'h0001_0ABC, 1'b0, 1'b0},
        {1'b0, 32'h0000_1000, 1'b1, 30'h0001_0000, 1'b1, 1'b0},
        {1'b1, 32'h1234_5FFF, 1'b1, 30'h2ABC_DFFF, 1'b0, 1'b0},
        {1'b0, 32'h1234_5001, 1'b1, 30'h2ABC_D001, 1'b1, 1'b1},
        {1'b0, 32'h0000_2ABC, 1'b0, 30'h0000_0000, 1'b0, 1'b0},
        {1'b1, 32'hFFFF_F123, 1'b1, 30'h3FFF_F123, 1'b0, 1'b0},
        {1'b1, 32'hFFFF_F000, 1'b1, 30'h3FFF_F000, 1'b1, 1'b1},
        {1'b0, 32'h8000_0777, 1'b1, 30'h0000_0777, 1'b0, 1'b0},
        {1'b1, 32'h7FFF_F777, 1'b0, 30'h0000_0000, 1'b0, 1'b0}
    };

    task automatic look(input string tag, input logic [31:0] va, input logic wr,
                        input logic e_hit, input logic [29:0] e_pa,
                        input logic e_ref, input logic e_dirty);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_write = wr; lkp_vaddr = va;
        #1;
        n_chk++;
        if (lkp_hit !== e_hit || lkp_paddr !== e_pa || lkp_ref !== e_ref || lkp_dirty !== e_dirty) begin
            n_fail++;
            $display("FAIL %s va=%h: got hit=%b pa=%h ref=%b dirty=%b, expected hit=%b pa=%h ref=%b dirty=%b",
                     tag, va, lkp_hit, lkp_paddr, lkp_ref, lkp_dirty, e_hit, e_pa, e_ref, e_dirty);
        end
        @(posedge clk); #1;
        lkp_valid = 1'b0; lkp_write = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [17:0] ppn,
                        input logic r, input logic d);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_ref = r; fill_dirty = d;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: hit is low while in reset
        #1; lkp_valid = 1'b1; lkp_vaddr = 32'h0000_0000; #1;
        n_chk++;
        if (lkp_hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 hit during reset: got %b expected 0", lkp_hit);
        end
        lkp_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look("R1", 32'h0000_1000, 1'b0, 1'b0, 30'h0, 1'b0, 1'b0);
        look("R1", 32'hFFFF_F000, 1'b0, 1'b0, 30'h0, 1'b0, 1'b0);

        fill(20'h00001, 18'h00010, 1'b0, 1'b0);
        fill(20'h12345, 18'h2ABCD, 1'b0, 1'b0);
        fill(20'hFFFFF, 18'h3FFFF, 1'b0, 1'b0);
        fill(20'h80000, 18'h00000, 1'b0, 1'b0);

        // R2 R3 R4 R5 R6: vector walk
        for (int i = 0; i < 9; i++) begin
            look("R2 R3 R4 R5 R6 vector", VEC[i][64:33], VEC[i][65], VEC[i][32],
                 VEC[i][31:2], VEC[i][1], VEC[i][0]);
        end

        // R7: clear together with a hit on page 0x00001
        @(negedge clk);
        clr_ref = 1'b1; lkp_valid = 1'b1; lkp_write = 1'b0; lkp_vaddr = 32'h0000_1000;
        @(posedge clk); #1;
        clr_ref = 1'b0; lkp_valid = 1'b0;
        look("R7 cleared", 32'h1234_5000, 1'b0, 1'b1, 30'h2ABC_D000, 1'b0, 1'b1);
        look("R7 same-cycle hit", 32'h0000_1000, 1'b0, 1'b1, 30'h0001_0000, 1'b1, 1'b0);

        // R11: status bits taken from the refill
        fill(20'h0ABCD, 18'h00123, 1'b1, 1'b1);
        look("R11", 32'h0ABC_D010, 1'b0, 1'b1, 30'h0012_3010, 1'b1, 1'b1);

        // R9: refill of a present page overwrites it
        fill(20'h00001, 18'h00020, 1'b0, 1'b0);
        look("R9", 32'h0000_1004, 1'b0, 1'b1, 30'h0002_0004, 1'b0, 1'b0);

        // R8: flush beats a same-cycle refill
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h55555; fill_ppn = 18'h01111;
        fill_ref = 1'b0; fill_dirty = 1'b0;
        @(posedge clk); #1;
        flush = 1'b0; fill_valid = 1'b0;
        look("R8 refill dropped", 32'h5555_5000, 1'b0, 1'b0, 30'h0, 1'b0, 1'b0);
        look("R8 old entry gone", 32'h1234_5000, 1'b0, 1'b0, 30'h0, 1'b0, 1'b0);

        // R10: fill every slot, then replace past capacity
        for (int i = 0; i < 16; i++) fill(20'h40000 + 20'(i), 18'h00100 + 18'(i), 1'b0, 1'b0);
        look("R10 first", 32'h4000_0000, 1'b0, 1'b1, 30'h0010_0000, 1'b0, 1'b0);
        look("R10 last", 32'h4000_F000, 1'b0, 1'b1, 30'h0010_F000, 1'b0, 1'b0);
        fill(20'h60000, 18'h00200, 1'b0, 1'b0);
        fill(20'h60001, 18'h00201, 1'b0, 1'b0);
        look("R10 evict slot0", 32'h4000_0000, 1'b0, 1'b0, 30'h0, 1'b0, 1'b0);
        look("R10 evict slot1", 32'h4000_1000, 1'b0, 1'b0, 30'h0, 1'b0, 1'b0);
        look("R10 survivor", 32'h4000_2000, 1'b0, 1'b1, 30'h0010_2000, 1'b0, 1'b0);
        look("R10 new a", 32'h6000_0000, 1'b0, 1'b1, 30'h0020_0000, 1'b0, 1'b0);
        look("R10 new b", 32'h6000_1000, 1'b0, 1'b1, 30'h0020_1000, 1'b0, 1'b0);
        fill(20'h60002, 18'h00202, 1'b0, 1'b0);
        look("R10 evict slot2", 32'h4000_2000, 1'b0, 1'b0, 30'h0, 1'b0, 1'b0);
        look("R10 slot3 kept", 32'h4000_3000, 1'b0, 1'b1, 30'h0010_3000, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule